// File: doc/BRIEF.md
# Banked GPIO Controller with Alternate-Function Select

This block is a register-mapped general-purpose I/O controller for up to 64 pins behind a plain 32-bit register bus (byte address, write strobe, write data, combinational read data). Pins are grouped into 32-pin banks. Every register exists once per bank. The word for a bank sits at its base offset scaled by the bank count, plus four bytes per bank index. With the default 64 pins there are two banks, so the scale factor is 2.

For each pin the controller holds an output bit, an output-enable bit and a 2-bit function select. Output bits are changed with write-one-to-set and write-one-to-clear words. The pin input passes through a two-flop synchronizer and can be read back. Each pin can capture interrupts in one of two sense modes: any edge, or level-high. Captured events sit in sticky pending bits. A per-pin enable masks them into an identity word, and one registered interrupt line is the OR of all identity bits. The function-select words use their own interleaved layout, because a downstream pad mux decodes them. The pad mux and the pad analog controls are outside this block.

Top module: `gpio_altfn_ctrl`

## Requirements
- R1: After reset, out_o, oe_o and fsel_o are all zero, irq_o is low, and the output-value word reads zero.
- R2: A write to the set word (base 0x00) turns on each output bit of that bank whose data bit is 1. Bits written as 0 keep their value.
- R3: A write to the clear word (base 0x04) turns off each output bit of that bank whose data bit is 1. Bits written as 0 keep their value.
- R4: The output-enable word (base 0x10) is written and read directly and drives oe_o. A 1 marks the pin as an output.
- R5: A pin's select bit 0 lives in the select-0 word and its select bit 1 lives in the select-1 word, at the pin's bit position. The word for bank b and select bit m is at 0x20*banks + 4*(m + banks*b), which with 64 pins gives 0x40, 0x44, 0x48 and 0x4C. Pin p drives fsel_o[2p+1:2p] = {sel1, sel0}. Code 0 is plain GPIO, and codes 1 to 3 pick an alternate function.
- R6: The input word (base 0x0C) shows pin_i through two synchronizer flops. A change is not visible after one clock edge and is visible after two.
- R7: With sense bit 0 (sense word, base 0x28), both a rising and a falling synchronized transition set the pin's pending bit, whether or not the pin is enabled.
- R8: With sense bit 1 (level-high), a pin that is high and enabled sets its pending bit on every cycle, even right after a clear. A disabled level pin never sets it.
- R9: Pending bits (base 0x14) are sticky and are cleared by writing 1. If a new event arrives in the same cycle as the clear, the bit stays set.
- R10: The identity word (base 0x1C) reads as pending AND enable (base 0x18). irq_o is a registered OR of all identity bits and goes high or low one clock after the identity word changes.
- R11: Reads of the set word, the clear word and unmapped addresses return zero.
- R12: A write to one bank's word leaves the other bank's pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| pin_i | input | NUM_PINS | Asynchronous pad inputs |
| out_o | output | NUM_PINS | Output values |
| oe_o | output | NUM_PINS | Output enables |
| fsel_o | output | 2*NUM_PINS | Function select, two bits per pin |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two things can land on a pending bit in the same clock: a software write-one clear and a freshly detected event. The bench lines up a synchronized falling edge of an edge-mode pin with the exact cycle in which the clear is written. It does this by counting the two synchronizer edges plus the edge-compare stage, then checks that the pending bit survives. For a level-high pin that is held high and enabled, the bench checks that a clear cannot drop the bit, and that the same clear does remove it once the pin is low.

// File: rtl/gpio_altfn_pkg.sv
package gpio_altfn_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned OFS_SET   = 32'h00;
  localparam int unsigned OFS_CLR   = 32'h04;
  localparam int unsigned OFS_OUT   = 32'h08;
  localparam int unsigned OFS_IN    = 32'h0C;
  localparam int unsigned OFS_OE    = 32'h10;
  localparam int unsigned OFS_PEND  = 32'h14;
  localparam int unsigned OFS_ENA   = 32'h18;
  localparam int unsigned OFS_IDENT = 32'h1C;
  localparam int unsigned OFS_FSEL  = 32'h20;
  localparam int unsigned OFS_SENSE = 32'h28;

  // plain registers: base scaled by bank count, then one word per bank
  function automatic logic [31:0] bank_addr(int unsigned base, int unsigned banks,
                                            int unsigned bank);
    return 32'(base * banks + 4 * bank);
  endfunction

  // select words interleave select bit within bank
  function automatic logic [31:0] fsel_addr(int unsigned msb, int unsigned banks,
                                            int unsigned bank);
    return 32'(OFS_FSEL * banks + 4 * (msb + banks * bank));
  endfunction
endpackage

// File: rtl/gpio_altfn_sync.sv
module gpio_altfn_sync #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_altfn_irq.sv
module gpio_altfn_irq #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] pin_mask_i,
  input  logic [WIDTH-1:0] clr_mask_i,
  input  logic [WIDTH-1:0] wr_val_i,
  input  logic [WIDTH-1:0] ena_wmask_i,
  input  logic [WIDTH-1:0] sense_wmask_i,
  output logic [WIDTH-1:0] pend_o,
  output logic [WIDTH-1:0] ena_o,
  output logic [WIDTH-1:0] sense_o,
  output logic [WIDTH-1:0] ident_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] prev_q, pend_q, ena_q, sense_q;
  logic [WIDTH-1:0] edge_ev, level_ev, set_ev;
  logic             irq_q;

  // sense bit 0: any edge, 1: level-high (gated by enable)
  assign edge_ev  = (sync_i ^ prev_q) & ~sense_q;
  assign level_ev = sync_i & sense_q & ena_q;
  assign set_ev   = (edge_ev | level_ev) & pin_mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      pend_q  <= '0;
      ena_q   <= '0;
      sense_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      prev_q  <= sync_i;
      pend_q  <= (pend_q & ~clr_mask_i) | set_ev;  // new event beats clear
      ena_q   <= ((ena_q & ~ena_wmask_i) | (wr_val_i & ena_wmask_i)) & pin_mask_i;
      sense_q <= ((sense_q & ~sense_wmask_i) | (wr_val_i & sense_wmask_i)) & pin_mask_i;
      irq_q   <= |(pend_q & ena_q);
    end
  end

  assign pend_o  = pend_q;
  assign ena_o   = ena_q;
  assign sense_o = sense_q;
  assign ident_o = pend_q & ena_q;
  assign irq_o   = irq_q;

  p_w1c_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & $past(clr_mask_i & ~set_ev)) == '0));
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~pend_q & $past(pend_q & ~clr_mask_i)) == '0));
  p_level_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~pend_q & $past(sync_i & sense_q & ena_q & pin_mask_i)) == '0));
  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ident_o == '0) |=> !irq_o);
endmodule

// File: rtl/gpio_altfn_ctrl.sv
module gpio_altfn_ctrl
  import gpio_altfn_pkg::*;
#(
  parameter int unsigned NUM_PINS = 64,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_PINS-1:0]   pin_i,
  output logic [NUM_PINS-1:0]   out_o,
  output logic [NUM_PINS-1:0]   oe_o,
  output logic [2*NUM_PINS-1:0] fsel_o,
  output logic                  irq_o
);
  localparam int unsigned NUM_BANKS = 1 + (NUM_PINS - 1) / WORD_W;
  localparam int unsigned PAD_W     = NUM_BANKS * WORD_W;

  logic [31:0]      addr_ext;
  logic [PAD_W-1:0] pin_mask, pins_pad, pins_sync, wdata_rep;
  logic [PAD_W-1:0] out_q, out_d, oe_q, oe_d, fs0_q, fs0_d, fs1_q, fs1_d;
  logic [PAD_W-1:0] clr_mask, ena_wmask, sense_wmask;
  logic [PAD_W-1:0] pend, ena, sense, ident;

  assign addr_ext  = 32'(addr_i);
  assign pins_pad  = PAD_W'(pin_i);
  assign wdata_rep = {NUM_BANKS{wdata_i}};

  for (genvar i = 0; i < PAD_W; i++) begin : g_mask
    assign pin_mask[i] = (i < NUM_PINS);
  end

  gpio_altfn_sync #(.WIDTH(PAD_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pins_pad),
    .sync_o (pins_sync)
  );

  gpio_altfn_irq #(.WIDTH(PAD_W)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sync_i       (pins_sync),
    .pin_mask_i   (pin_mask),
    .clr_mask_i   (clr_mask),
    .wr_val_i     (wdata_rep),
    .ena_wmask_i  (ena_wmask),
    .sense_wmask_i(sense_wmask),
    .pend_o       (pend),
    .ena_o        (ena),
    .sense_o      (sense),
    .ident_o      (ident),
    .irq_o        (irq_o)
  );

  // write decode
  always_comb begin
    out_d       = out_q;
    oe_d        = oe_q;
    fs0_d       = fs0_q;
    fs1_d       = fs1_q;
    clr_mask    = '0;
    ena_wmask   = '0;
    sense_wmask = '0;
    if (we_i) begin
      for (int k = 0; k < NUM_BANKS; k++) begin
        if (addr_ext == bank_addr(OFS_SET, NUM_BANKS, k))
          out_d[k*WORD_W +: WORD_W] = out_q[k*WORD_W +: WORD_W] | wdata_i;
        if (addr_ext == bank_addr(OFS_CLR, NUM_BANKS, k))
          out_d[k*WORD_W +: WORD_W] = out_q[k*WORD_W +: WORD_W] & ~wdata_i;
        if (addr_ext == bank_addr(OFS_OE, NUM_BANKS, k))
          oe_d[k*WORD_W +: WORD_W] = wdata_i;
        if (addr_ext == bank_addr(OFS_PEND, NUM_BANKS, k))
          clr_mask[k*WORD_W +: WORD_W] = wdata_i;
        if (addr_ext == bank_addr(OFS_ENA, NUM_BANKS, k))
          ena_wmask[k*WORD_W +: WORD_W] = '1;
        if (addr_ext == bank_addr(OFS_SENSE, NUM_BANKS, k))
          sense_wmask[k*WORD_W +: WORD_W] = '1;
        if (addr_ext == fsel_addr(0, NUM_BANKS, k))
          fs0_d[k*WORD_W +: WORD_W] = wdata_i;
        if (addr_ext == fsel_addr(1, NUM_BANKS, k))
          fs1_d[k*WORD_W +: WORD_W] = wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      oe_q  <= '0;
      fs0_q <= '0;
      fs1_q <= '0;
    end else begin
      out_q <= out_d & pin_mask;
      oe_q  <= oe_d & pin_mask;
      fs0_q <= fs0_d & pin_mask;
      fs1_q <= fs1_d & pin_mask;
    end
  end

  // read mux; set, clear and holes read zero
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (addr_ext == bank_addr(OFS_OUT, NUM_BANKS, k))   rdata_o = out_q[k*WORD_W +: WORD_W];
      if (addr_ext == bank_addr(OFS_IN, NUM_BANKS, k))    rdata_o = pins_sync[k*WORD_W +: WORD_W];
      if (addr_ext == bank_addr(OFS_OE, NUM_BANKS, k))    rdata_o = oe_q[k*WORD_W +: WORD_W];
      if (addr_ext == bank_addr(OFS_PEND, NUM_BANKS, k))  rdata_o = pend[k*WORD_W +: WORD_W];
      if (addr_ext == bank_addr(OFS_ENA, NUM_BANKS, k))   rdata_o = ena[k*WORD_W +: WORD_W];
      if (addr_ext == bank_addr(OFS_IDENT, NUM_BANKS, k)) rdata_o = ident[k*WORD_W +: WORD_W];
      if (addr_ext == bank_addr(OFS_SENSE, NUM_BANKS, k)) rdata_o = sense[k*WORD_W +: WORD_W];
      if (addr_ext == fsel_addr(0, NUM_BANKS, k))         rdata_o = fs0_q[k*WORD_W +: WORD_W];
      if (addr_ext == fsel_addr(1, NUM_BANKS, k))         rdata_o = fs1_q[k*WORD_W +: WORD_W];
    end
  end

  assign out_o = out_q[NUM_PINS-1:0];
  assign oe_o  = oe_q[NUM_PINS-1:0];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_fsel
    assign fsel_o[2*p +: 2] = {fs1_q[p], fs0_q[p]};
  end

  p_set_bits_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_ext == bank_addr(OFS_SET, NUM_BANKS, 0))
      |=> ((out_q[WORD_W-1:0] & $past(wdata_i)) == $past(wdata_i)));
  p_clr_bits_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_ext == bank_addr(OFS_CLR, NUM_BANKS, 0))
      |=> ((out_q[WORD_W-1:0] & $past(wdata_i)) == '0));
  p_fsel_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(fsel_o));
  p_out_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(out_o));
endmodule

// File: tb/gpio_altfn_ctrl_tb_top.sv
module gpio_altfn_ctrl_tb_top;
  localparam int NP = 64;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] out, oe;
  logic [2*NP-1:0] fsel;
  logic          irq;
  int            errors = 0;
  int            checks = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  gpio_altfn_ctrl #(.NUM_PINS(NP), .ADDR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .out_o(out), .oe_o(oe), .fsel_o(fsel), .irq_o(irq)
  );

  function automatic logic [7:0] ra(int base, int bank);
    return 8'(base * NB + 4 * bank);
  endfunction
  function automatic logic [7:0] fa(int msb, int bank);
    return 8'(32'h20 * NB + 4 * (msb + NB * bank));
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 out", out, 0);
    check("R1 oe", oe, 0);
    check("R1 fsel", fsel, 0);
    check("R1 irq", irq, 0);
    rd(ra('h08, 0), d); check("R1 out word", d, 0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    wr(ra('h00, 0), 32'hF0);   check("R2 set", out, 64'hF0);
    wr(ra('h00, 0), 32'h01);   check("R2 set keeps", out, 64'hF1);
    wr(ra('h04, 0), 32'h30);   check("R3 clear", out, 64'hC1);
    rd(ra('h08, 0), d);        check("R3 out word", d, 32'hC1);
    rd(ra('h00, 0), d);        check("R11 set word reads 0", d, 0);
    rd(ra('h04, 1), d);        check("R11 clear word reads 0", d, 0);
    rd(8'h58, d);              check("R11 hole 0x58", d, 0);
    rd(8'hFC, d);              check("R11 hole 0xFC", d, 0);
  endtask

  task automatic t_bank();
    wr(ra('h00, 1), 32'h8000_0001);
    check("R12 high bank set", out, 64'h8000_0001_0000_00C1);
    wr(ra('h04, 1), 32'h0000_0001);
    check("R12 high bank clear", out, 64'h8000_0000_0000_00C1);
  endtask

  task automatic t_oe();
    logic [31:0] d;
    wr(ra('h10, 1), 32'hFFFF_0000);
    check("R4 oe pins", oe, 64'hFFFF_0000_0000_0000);
    rd(ra('h10, 1), d); check("R4 oe word", d, 32'hFFFF_0000);
  endtask

  task automatic t_fsel();
    logic [31:0] d;
    logic [127:0] e;
    e = '0; e[11:10] = 2'd3; e[81:80] = 2'd2; e[83:82] = 2'd1;
    check("R5 fsel addr map", {fa(0, 0), fa(1, 0), fa(0, 1), fa(1, 1)}, 32'h40_44_48_4C);
    wr(fa(0, 0), 32'h1 << 5);
    wr(fa(1, 0), 32'h1 << 5);
    wr(fa(1, 1), 32'h1 << 8);
    wr(fa(0, 1), 32'h1 << 9);
    check("R5 fsel pins", fsel, e);
    rd(fa(1, 1), d); check("R5 sel1 high word", d, 32'h100);
    check("R12 fsel write leaves out", out, 64'h8000_0000_0000_00C1);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk); pins[3] = 1'b1; pins[33] = 1'b1;
    rd(ra('h0C, 0), d); check("R6 one edge not visible", d, 0);
    rd(ra('h0C, 0), d); check("R6 two edges visible", d, 32'h8);
    rd(ra('h0C, 1), d); check("R6 high bank", d, 32'h2);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    tick(2);
    rd(ra('h14, 0), d); check("R7 rise pending while disabled", d, 32'h8);
    rd(ra('h14, 1), d); check("R7 rise pending high bank", d, 32'h2);
    rd(ra('h1C, 0), d); check("R10 ident masked", d, 0);
    check("R10 irq low when masked", irq, 0);
    wr(ra('h14, 0), 32'hFFFF_FFFF);
    wr(ra('h14, 1), 32'hFFFF_FFFF);
    rd(ra('h14, 0), d); check("R9 w1c", d, 0);
    @(negedge clk); pins[3] = 1'b0;
    tick(3);
    rd(ra('h14, 0), d); check("R7 fall pending", d, 32'h8);
    wr(ra('h18, 0), 32'h8);
    rd(ra('h1C, 0), d); check("R10 ident", d, 32'h8);
    check("R10 irq high", irq, 1);
    wr(ra('h14, 0), 32'h8);
    rd(ra('h14, 0), d); check("R9 cleared", d, 0);
    check("R10 irq low after clear", irq, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(ra('h28, 0), 32'h50);   // pins 4 and 6 level-high
    wr(ra('h18, 0), 32'h10);   // only pin 4 enabled
    @(negedge clk); pins[4] = 1'b1; pins[6] = 1'b1;
    tick(4);
    rd(ra('h14, 0), d); check("R8 level pending, disabled pin ignored", d, 32'h10);
    wr(ra('h14, 0), 32'h50);
    rd(ra('h14, 0), d); check("R8 reasserts after clear", d, 32'h10);
    check("R10 irq level", irq, 1);
    @(negedge clk); pins[4] = 1'b0; pins[6] = 1'b0;
    tick(3);
    wr(ra('h14, 0), 32'h10);
    rd(ra('h14, 0), d); check("R8 clear after low", d, 0);
    wr(ra('h28, 0), 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk); pins[7] = 1'b1;
    tick(3);
    rd(ra('h14, 0), d); check("R7 pin7 rise", d, 32'h80);
    @(negedge clk); pins[7] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    wr(ra('h14, 0), 32'h80);   // lands on the edge that sees the fall
    rd(ra('h14, 0), d); check("R9 event beats clear", d, 32'h80);
    wr(ra('h14, 0), 32'h80);
    rd(ra('h14, 0), d); check("R9 later clear", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_set_clear();
    t_bank();
    t_oe();
    t_fsel();
    t_input();
    t_edge();
    t_level();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule